// File: doc/BRIEF.md
# Stereo DAC Volume Serial Loader

This block writes a pair of volume settings into an external audio DAC over a three-wire serial link: a data line, a serial clock and a latch. A single start strobe starts a transfer. The block then packs two 16-bit control words, one for the left channel and one for the right. It shifts each word out most significant bit first and closes each word with a latch pulse. The left word is always sent first. While a transfer is in flight the block holds `busy_o` high.

Two word layouts are supported, and `dac_sel_i` picks between them at the start strobe. Serial timing comes from a divider tick. The parameter `HALF_CYC` sets the number of system clocks in each serial phase. Choose it so that every phase lasts at least about one microsecond, since the DAC cannot accept faster shifting.

The sequencer has five states:

| State | What it does |
|---|---|
| `S_IDLE` | Waits for a start strobe. |
| `S_BIT_LO` | Presents a data bit with the clock low. |
| `S_BIT_HI` | Raises the clock. |
| `S_LATCH` | Holds the latch high for two phases, with clock and data low. |
| `S_GAP` | Latch-low pause of one phase. |

The transitions are:

| From | To | Condition |
|---|---|---|
| `S_IDLE` | `S_BIT_LO` | Start strobe. |
| `S_BIT_LO` | `S_BIT_HI` | Tick. |
| `S_BIT_HI` | `S_BIT_LO` | Tick, with bits still to send. |
| `S_BIT_HI` | `S_LATCH` | Tick after the last bit. |
| `S_LATCH` | `S_GAP` | Second tick. |
| `S_GAP` | `S_BIT_LO` | Tick after the left word, with the right word loaded. |
| `S_GAP` | `S_IDLE` | Tick after the right word. |

Top module: `dac_vol_loader`

## Requirements
- R1: Each word has 16 bits and is sent most significant bit first. Each bit is valid on `sdata_o` before `sclk_o` rises, so the receiver samples on the rising clock edge.
- R2: `sdata_o` does not change while `sclk_o` is high, and `slatch_o` stays low during the data bits.
- R3: After the 16th bit, `sclk_o` and `sdata_o` are low and `slatch_o` is high for exactly 2*HALF_CYC clocks. The latch then falls, followed by a one-phase gap with all three lines low.
- R4: With `dac_sel_i`=0 (layout A), the word is {vol[13:0], ch, 0}. Here ch is 0 for left and 1 for right, so the channel flag is bit 1 and bit 0 is 0.
- R5: With `dac_sel_i`=1 (layout B), bits 9:0 carry vol[9:0], bit 10 is the channel flag (0 left, 1 right) and bits 15:11 are 0. Volume bits 13:10 have no effect.
- R6: The left word is sent and latched before the right word.
- R7: Every clock-high phase lasts exactly HALF_CYC system clocks.
- R8: `busy_o` rises on the clock after an accepted start. It stays high for exactly 70*HALF_CYC clocks and falls one phase after the second latch falls.
- R9: A start strobe that arrives while `busy_o` is high has no effect on the words sent or on the transfer length.
- R10: Both volumes and the layout select are taken at the accepted start strobe. Later changes to these inputs do not alter the transfer.
- R11: During reset, all serial outputs and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| vol_left_i | input | 14 | Left channel volume |
| vol_right_i | input | 14 | Right channel volume |
| dac_sel_i | input | 1 | Word layout: 0 = layout A, 1 = layout B |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Serial clock |
| slatch_o | output | 1 | Word latch strobe |
| busy_o | output | 1 | Transfer in progress |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- The clock and the latch are never high together.
- Data is steady across each clock-high phase.
- The latch rises only after the last bit.
- Ticks are never adjacent.
- A start seen while busy leaves the captured right-channel settings untouched.
- `busy_o` falls only after the right word.

Some properties can only be shown by the bench scenarios. These are the exact word contents under both layouts, the left-before-right order, and the precise phase and busy lengths. The same holds for immunity to input changes and to repeated starts in mid-transfer. The bench decodes these from the serial lines and compares them with words it computes itself.

// File: rtl/dvl_pkg.sv
package dvl_pkg;
    localparam int WORD_W    = 16;
    localparam int VOL_W     = 14;
    localparam int VOL_B_W   = 10;
    localparam int CH_POS_A  = 1;
    localparam int CH_POS_B  = 10;
    localparam int BITCNT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_BIT_LO,
        S_BIT_HI,
        S_LATCH,
        S_GAP
    } seq_state_t;
endpackage

// File: rtl/dvl_tick.sv
module dvl_tick #(
    parameter int HALF_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    // R7: a phase never shrinks to a single clock
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/dvl_pack.sv
module dvl_pack
    import dvl_pkg::*;
(
    input  logic [VOL_W-1:0]  vol_i,
    input  logic              chan_i,
    input  logic              sel_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o = '0;
        if (!sel_i) begin
            word_o[WORD_W-1:CH_POS_A+1] = vol_i[WORD_W-CH_POS_A-2:0];
            word_o[CH_POS_A]            = chan_i;
        end else begin
            word_o[VOL_B_W-1:0] = vol_i[VOL_B_W-1:0];
            word_o[CH_POS_B]    = chan_i;
        end
    end
endmodule

// File: rtl/dac_vol_loader.sv
module dac_vol_loader
    import dvl_pkg::*;
#(
    parameter int HALF_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VOL_W-1:0] vol_left_i,
    input  logic [VOL_W-1:0] vol_right_i,
    input  logic             dac_sel_i,
    output logic             sdata_o,
    output logic             sclk_o,
    output logic             slatch_o,
    output logic             busy_o
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(WORD_W - 1);

    seq_state_t          state_q, state_d;
    logic [WORD_W-1:0]   shreg_q;
    logic [BITCNT_W-1:0] bit_cnt_q;
    logic                lat_ph_q;
    logic                chan_q;
    logic [VOL_W-1:0]    vol_r_q;
    logic                sel_q;
    logic                tick;
    logic [WORD_W-1:0]   word_l, word_r;

    dvl_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != S_IDLE),
        .tick_o (tick)
    );

    dvl_pack u_pack_l (.vol_i(vol_left_i), .chan_i(1'b0), .sel_i(dac_sel_i), .word_o(word_l));
    dvl_pack u_pack_r (.vol_i(vol_r_q),    .chan_i(1'b1), .sel_i(sel_q),     .word_o(word_r));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_BIT_LO;
            S_BIT_LO: if (tick) state_d = S_BIT_HI;
            S_BIT_HI: if (tick) state_d = (bit_cnt_q == '0) ? S_LATCH : S_BIT_LO;
            S_LATCH:  if (tick && lat_ph_q) state_d = S_GAP;
            S_GAP:    if (tick) state_d = chan_q ? S_IDLE : S_BIT_LO;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            lat_ph_q  <= 1'b0;
            chan_q    <= 1'b0;
            vol_r_q   <= '0;
            sel_q     <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    shreg_q   <= word_l;
                    bit_cnt_q <= LAST_BIT;
                    chan_q    <= 1'b0;
                    lat_ph_q  <= 1'b0;
                    vol_r_q   <= vol_right_i;
                    sel_q     <= dac_sel_i;
                end
                S_BIT_HI: if (tick && bit_cnt_q != '0) begin
                    shreg_q   <= {shreg_q[WORD_W-2:0], 1'b0};
                    bit_cnt_q <= bit_cnt_q - 1'b1;
                end
                S_LATCH: if (tick) lat_ph_q <= ~lat_ph_q;
                S_GAP: if (tick && !chan_q) begin
                    shreg_q   <= word_r;
                    bit_cnt_q <= LAST_BIT;
                    chan_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sdata_o  = 1'b0;
        sclk_o   = 1'b0;
        slatch_o = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            S_IDLE:   busy_o = 1'b0;
            S_BIT_LO: sdata_o = shreg_q[WORD_W-1];
            S_BIT_HI: begin
                sdata_o = shreg_q[WORD_W-1];
                sclk_o  = 1'b1;
            end
            S_LATCH:  slatch_o = 1'b1;
            S_GAP:    ;
            default:  busy_o = 1'b0;
        endcase
    end

    // R3: latch and clock never overlap
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_o && slatch_o));
    // R2: data steady while clock high
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
    // R3: latch only rises after the final bit
    p_latch_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slatch_o) |-> (bit_cnt_q == '0));
    // R9: a start while busy does not retake the settings
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(vol_r_q) && $stable(sel_q)));
    // R8: busy ends only after the right word, latch already low
    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(chan_q) && !slatch_o));
endmodule

// File: tb/dac_vol_loader_tb.sv
`timescale 1ns/1ps
module dac_vol_loader_tb;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [13:0] vol_l = '0, vol_r = '0;
    logic dac_sel = 1'b0;
    logic sdata, sclk, slatch, busy;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_vol_loader #(.HALF_CYC(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .vol_left_i(vol_l), .vol_right_i(vol_r), .dac_sel_i(dac_sel),
        .sdata_o(sdata), .sclk_o(sclk), .slatch_o(slatch), .busy_o(busy)
    );

    function automatic logic [15:0] exp_word(logic [13:0] v, logic ch, logic sel);
        if (!sel) return {v, ch, 1'b0};
        return {5'b0, ch, v[9:0]};
    endfunction

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic run_xfer(logic [13:0] vl, logic [13:0] vr, logic sel, bit disturb);
        logic [15:0] words [2];
        logic [15:0] cur = '0;
        int nw = 0, nb = 0, blen = 0, hrun = 0, lrun = 0;
        int hmin = 1000, hmax = 0, dchg = 0, latbad = 0, lenbad = 0, bitbad = 0;
        logic psclk = 1'b0, psdata = 1'b0, plat = 1'b0;
        words[0] = '0; words[1] = '0;
        @(negedge clk);
        vol_l = vl; vol_r = vr; dac_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy rises after start", busy, 1);
        while (busy && blen < 2000) begin
            blen++;
            if (disturb && blen == 50) begin
                start = 1'b1; vol_l = ~vl; vol_r = ~vr; dac_sel = ~sel;
            end else if (disturb && blen == 51) begin
                start = 1'b0;
            end
            if (sclk) hrun++;
            else if (hrun > 0) begin
                if (hrun < hmin) hmin = hrun;
                if (hrun > hmax) hmax = hrun;
                hrun = 0;
            end
            if (sclk && !psclk) begin
                cur = {cur[14:0], sdata};
                nb++;
            end
            if (sclk && psclk && sdata != psdata) dchg++;
            if (slatch) begin
                lrun++;
                if (sclk || sdata) latbad++;
            end
            if (slatch && !plat) begin
                if (nw < 2) words[nw] = cur;
                if (nb != 16) bitbad++;
                nw++; nb = 0;
            end
            if (!slatch && plat) begin
                if (lrun != 2 * H) lenbad++;
                lrun = 0;
            end
            psclk = sclk; psdata = sdata; plat = slatch;
            @(negedge clk);
        end
        chk(nw == 2, "R6 two latched words", nw, 2);
        chk(bitbad == 0, "R1 sixteen bits per word", bitbad, 0);
        chk(words[0] == exp_word(vl, 1'b0, sel), sel ? "R5 R1 left word" : "R4 R1 left word",
            words[0], exp_word(vl, 1'b0, sel));
        chk(words[1] == exp_word(vr, 1'b1, sel), sel ? "R5 R6 right word" : "R4 R6 right word",
            words[1], exp_word(vr, 1'b1, sel));
        chk(hmin == H && hmax == H, "R7 clock high phase", hmax, H);
        chk(dchg == 0, "R2 data steady with clock high", dchg, 0);
        chk(latbad == 0 && lenbad == 0, "R3 latch pulse shape", latbad + lenbad, 0);
        chk(blen == 70 * H, disturb ? "R8 R9 R10 busy length" : "R8 busy length", blen, 70 * H);
        vol_l = vl; vol_r = vr; dac_sel = sel;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk({sdata, sclk, slatch, busy} == 4'b0, "R11 reset outputs", {sdata, sclk, slatch, busy}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk({sdata, sclk, slatch, busy} == 4'b0, "R11 idle after reset", {sdata, sclk, slatch, busy}, 0);
        // directed corners
        run_xfer(14'h3FFF, 14'h0000, 1'b0, 1'b0);   // R4
        run_xfer(14'h0000, 14'h3FFF, 1'b1, 1'b0);   // R5: high vol bits ignored
        run_xfer(14'h3C00, 14'h2AAA, 1'b1, 1'b0);   // R5
        run_xfer(14'h1234, 14'h2345, 1'b0, 1'b1);   // R9 R10
        run_xfer(14'h0155, 14'h02AA, 1'b1, 1'b1);   // R9 R10
        // random
        for (int i = 0; i < 10; i++) begin
            run_xfer(14'($urandom), 14'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule